// File: doc/BRIEF.md
# Two-Level Polled Interrupt Controller

This block arbitrates interrupt requests for a small CPU. It serves six sources: two external request pins, three timer flags and one serial flag that already merges receive and transmit. Each source has an enable bit and a priority bit, and a global enable gates all of them. Once per machine cycle, on a strobe from the CPU, the block latches a snapshot of every request. At the next strobe it polls that snapshot and, if nothing blocks it, issues a one-clock vector request that carries a 16-bit vector address.

The block keeps one in-service bit for each of its two priority levels. A high-level request can interrupt low-level service. Nothing interrupts high-level service. The CPU reports whether the current clock is the last cycle of its instruction and whether that instruction must not be interrupted. A return-from-interrupt pulse releases the highest level that is active. Each external pin can detect falling edges or can request on a low level.

Top module: `irq_poll_ctrl`

## Requirements
- R1: While reset is held, `vec_req`, `in_svc` and `ext_flag` are all zero.
- R2: A request present at one `mc_stb` clock is only sampled. It can raise `vec_req` at the next `mc_stb` clock at the earliest. `vec_req` lasts one clock and never follows a clock without `mc_stb`.
- R3: Among eligible sampled requests, a source whose `src_hi` bit is 1 beats every source whose bit is 0. Within one level the lowest source position wins. The positions are: 0 external pin 0, 1 timer 0, 2 external pin 1, 3 timer 1, 4 serial, 5 timer 2.
- R4: The vector address for position p is 0x0003 + 8·p, giving 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 and 0x002B. `vec_hi` reports the granted level.
- R5: A source is eligible only when its `src_en` bit (same position) and `glb_en` are both 1.
- R6: A granted vector sets the `in_svc` bit of its level (bit 1 high, bit 0 low) in the same clock that `vec_req` is 1. A low-level grant requires both bits clear. A high-level grant requires bit 1 clear.
- R7: No vector is granted unless `insn_last` is 1 and `insn_block` is 0 at the polling clock.
- R8: A request that was blocked and is inactive by the next sample is never vectored. Polling uses only the latest sample.
- R9: With `ext_edge_sel[e]` = 1, a high sample of `ext_pin_n[e]` followed by a low sample sets `ext_flag[e]`. Taking that pin's vector clears the flag. A pin that stays low makes no further request.
- R10: With `ext_edge_sel[e]` = 0, a low sample requests directly, `ext_flag[e]` stays 0, and a pin held low requests again after return.
- R11: Timer and serial requests are never cleared by the block. A flag still high after return is vectored again.
- R12: A `reti_stb` pulse clears `in_svc[1]` if it is set, otherwise `in_svc[0]`. When it coincides with a grant, the clear and the new level's set both take effect in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_stb | input | 1 | One-clock machine-cycle strobe |
| ext_pin_n | input | 2 | External request pins, active low |
| ext_edge_sel | input | 2 | 1 = falling-edge detect, 0 = level request, per pin |
| tmr_flag | input | 3 | Timer 0, 1 and 2 request flags |
| ser_flag | input | 1 | Combined serial request flag |
| src_en | input | 6 | Per-source enable, indexed by source position |
| src_hi | input | 6 | Per-source priority, 1 = high level |
| glb_en | input | 1 | Global interrupt enable |
| insn_last | input | 1 | Current clock is the final cycle of the instruction |
| insn_block | input | 1 | Current instruction must not be interrupted |
| reti_stb | input | 1 | One-clock return-from-interrupt pulse |
| vec_req | output | 1 | One-clock vector request |
| vec_addr | output | 16 | Vector address, valid with `vec_req` |
| vec_hi | output | 1 | Level of the granted vector |
| in_svc | output | 2 | In-service bits: [1] high level, [0] low level |
| ext_flag | output | 2 | Edge-latched external request flags |

## Verification
A grant and a return release can both change `in_svc` in the same clock. The bench provokes this by pulsing `reti_stb` on the very strobe at which a pending request is polled, in two cases. In the first, a high request is pending during low service, so the result must be only the high bit. In the second, a low request is pending during high service, so the grant is refused against the old state and `in_svc` must read zero. A behavioural model in the bench recomputes the grant, the in-service bits and the edge flags every clock, and it is compared with the ports. An edge-mode pin whose vector is taken on the same strobe that resamples it is judged in the same way, so a stale flag cannot re-request.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
  localparam int NUM_SRC = 6;
  localparam int NUM_EXT = 2;
  localparam int NUM_TMR = 3;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int VEC_W   = 16;

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [IDX_W-1:0]   src_idx_t;

  // slot of external pin e in the polling order (pins sit at even slots)
  function automatic src_idx_t ext_slot(input int e);
    return src_idx_t'(2 * e);
  endfunction

  // lowest set position of a request vector
  function automatic src_idx_t first_one(input src_vec_t v);
    src_idx_t r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = src_idx_t'(i);
    end
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input src_idx_t idx,
                                               input logic [VEC_W-1:0] base,
                                               input logic [VEC_W-1:0] stride);
    return base + stride * {{(VEC_W-IDX_W){1'b0}}, idx};
  endfunction
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler
  import irq_poll_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stb,
  input  logic [NUM_EXT-1:0] ext_pin_n,
  input  logic [NUM_EXT-1:0] edge_sel,
  input  logic [NUM_EXT-1:0] ext_clr,
  input  logic [NUM_TMR-1:0] tmr_flag,
  input  logic               ser_flag,
  output src_vec_t           samp_q,
  output logic [NUM_EXT-1:0] flag_q
);
  logic [NUM_EXT-1:0] pin_q;
  logic [NUM_EXT-1:0] edge_seen;
  logic [NUM_EXT-1:0] flag_d;
  logic [NUM_EXT-1:0] ext_now;
  src_vec_t           raw;

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    assign edge_seen[e] = edge_sel[e] & pin_q[e] & ~ext_pin_n[e];
    assign flag_d[e]    = edge_sel[e] & ((flag_q[e] & ~ext_clr[e]) | edge_seen[e]);
    assign ext_now[e]   = edge_sel[e] ? flag_d[e] : ~ext_pin_n[e];
  end

  assign raw = {tmr_flag[2], ser_flag, tmr_flag[1], ext_now[1], tmr_flag[0], ext_now[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '1;
      flag_q <= '0;
      samp_q <= '0;
    end else if (stb) begin
      pin_q  <= ext_pin_n;
      flag_q <= flag_d;
      samp_q <= raw;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_poll_pkg::*;
(
  input  src_vec_t   samp,
  input  src_vec_t   en,
  input  src_vec_t   hi,
  input  logic       glb_en,
  input  logic       stb,
  input  logic       insn_last,
  input  logic       insn_block,
  input  logic [1:0] in_svc,
  output logic       grant,
  output logic       grant_hi,
  output src_idx_t   grant_idx
);
  src_vec_t elig, hi_set, lo_set;
  logic     any_hi, any, level_busy, blocked;

  assign elig       = samp & en & {NUM_SRC{glb_en}};
  assign hi_set     = elig & hi;
  assign lo_set     = elig & ~hi;
  assign any_hi     = |hi_set;
  assign any        = |elig;
  assign grant_hi   = any_hi;
  assign grant_idx  = first_one(any_hi ? hi_set : lo_set);
  assign level_busy = in_svc[1] | (~any_hi & in_svc[0]);
  assign blocked    = level_busy | ~insn_last | insn_block;
  assign grant      = stb & any & ~blocked;
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set,
  input  logic       set_hi,
  input  logic       ret,
  output logic [1:0] in_svc
);
  logic [1:0] clr_mask, set_mask;

  assign clr_mask = ret ? (in_svc[1] ? 2'b10 : 2'b01) : 2'b00;
  assign set_mask = set ? (set_hi ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_svc <= 2'b00;
    else        in_svc <= (in_svc & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/irq_poll_ctrl.sv
module irq_poll_ctrl
  import irq_poll_pkg::*;
#(
  parameter logic [VEC_W-1:0] VEC_BASE   = 16'h0003,
  parameter logic [VEC_W-1:0] VEC_STRIDE = 16'h0008
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mc_stb,
  input  logic [NUM_EXT-1:0] ext_pin_n,
  input  logic [NUM_EXT-1:0] ext_edge_sel,
  input  logic [NUM_TMR-1:0] tmr_flag,
  input  logic               ser_flag,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] src_hi,
  input  logic               glb_en,
  input  logic               insn_last,
  input  logic               insn_block,
  input  logic               reti_stb,
  output logic               vec_req,
  output logic [VEC_W-1:0]   vec_addr,
  output logic               vec_hi,
  output logic [1:0]         in_svc,
  output logic [NUM_EXT-1:0] ext_flag
);
  src_vec_t           samp;
  logic               grant, grant_hi;
  src_idx_t           grant_idx;
  logic [NUM_EXT-1:0] ext_clr;

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_clr
    assign ext_clr[e] = grant & (grant_idx == ext_slot(e)) & ext_edge_sel[e];
  end

  irq_sampler u_samp (
    .clk, .rst_n, .stb(mc_stb), .ext_pin_n, .edge_sel(ext_edge_sel),
    .ext_clr, .tmr_flag, .ser_flag, .samp_q(samp), .flag_q(ext_flag)
  );

  irq_arbiter u_arb (
    .samp, .en(src_en), .hi(src_hi), .glb_en, .stb(mc_stb), .insn_last,
    .insn_block, .in_svc, .grant, .grant_hi, .grant_idx
  );

  irq_level_track u_lvl (
    .clk, .rst_n, .set(grant), .set_hi(grant_hi), .ret(reti_stb), .in_svc
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_req  <= 1'b0;
      vec_addr <= '0;
      vec_hi   <= 1'b0;
    end else begin
      vec_req <= grant;
      if (grant) begin
        vec_addr <= vec_of(grant_idx, VEC_BASE, VEC_STRIDE);
        vec_hi   <= grant_hi;
      end
    end
  end
endmodule

// File: rtl/irq_poll_ctrl_chk.sv
module irq_poll_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mc_stb,
  input logic        insn_last,
  input logic        insn_block,
  input logic        glb_en,
  input logic        reti_stb,
  input logic [1:0]  ext_edge_sel,
  input logic [1:0]  ext_flag,
  input logic        vec_req,
  input logic [15:0] vec_addr,
  input logic        vec_hi,
  input logic [1:0]  in_svc,
  input logic        grant
);
  assert_vec_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $past(mc_stb));

  assert_vec_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (vec_addr[2:0] == 3'd3) && (vec_addr < 16'h0030));

  assert_glb_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $past(glb_en));

  assert_level_marked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (vec_hi ? in_svc[1] : in_svc[0]));

  assert_hi_not_nested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> !$past(in_svc[1]));

  assert_lo_needs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && !vec_hi) |-> ($past(in_svc) == 2'b00));

  assert_insn_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> ($past(insn_last) && !$past(insn_block)));

  for (genvar e = 0; e < 2; e++) begin : g_lvl
    assert_level_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mc_stb) && !$past(ext_edge_sel[e])) |-> !ext_flag[e]);
  end

  assert_reti_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_stb && !grant && in_svc == 2'b01) |=> (in_svc == 2'b00));
endmodule

bind irq_poll_ctrl irq_poll_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mc_stb(mc_stb), .insn_last(insn_last),
  .insn_block(insn_block), .glb_en(glb_en), .reti_stb(reti_stb),
  .ext_edge_sel(ext_edge_sel), .ext_flag(ext_flag), .vec_req(vec_req),
  .vec_addr(vec_addr), .vec_hi(vec_hi), .in_svc(in_svc), .grant(grant)
);

// File: tb/irq_poll_ctrl_tb.sv
module irq_poll_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk, rst_n, mc_stb, ser_flag, glb_en, insn_last, insn_block, reti_stb;
  logic [1:0]  ext_pin_n, ext_edge_sel, in_svc, ext_flag;
  logic [2:0]  tmr_flag;
  logic [5:0]  src_en, src_hi;
  logic        vec_req, vec_hi;
  logic [15:0] vec_addr;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  bit          got_req, got_hi;
  logic [15:0] got_addr;

  // behavioural reference state
  logic [1:0] m_pin, m_flag, m_svc;
  logic [5:0] m_samp;
  bit         m_req;
  int         m_addr;

  irq_poll_ctrl dut_i (
    .clk, .rst_n, .mc_stb, .ext_pin_n, .ext_edge_sel, .tmr_flag, .ser_flag,
    .src_en, .src_hi, .glb_en, .insn_last, .insn_block, .reti_stb,
    .vec_req, .vec_addr, .vec_hi, .in_svc, .ext_flag
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin : model_step
    int win, wlvl;
    bit ok, keep, edge_now, low;
    logic [1:0] svc_n, nf;
    logic [5:0] raw;
    if (!rst_n) begin
      m_pin = 2'b11; m_flag = 2'b00; m_svc = 2'b00; m_samp = '0; m_req = 0; m_addr = 0;
    end else begin
      win = -1; wlvl = 0;
      if (mc_stb)
        for (int lvl = 1; lvl >= 0; lvl--)
          for (int i = 0; i < 6; i++)
            if (win < 0 && m_samp[i] && src_en[i] && glb_en && (int'(src_hi[i]) == lvl)) begin
              win = i; wlvl = lvl;
            end
      ok = (win >= 0) && insn_last && !insn_block && !m_svc[1] && !(wlvl == 0 && m_svc[0]);
      svc_n = m_svc;
      if (reti_stb) begin
        if (svc_n[1]) svc_n[1] = 0; else svc_n[0] = 0;
      end
      if (ok) svc_n[wlvl] = 1;
      m_svc = svc_n;
      m_req = ok;
      if (ok) m_addr = 3 + 8 * win;
      if (mc_stb) begin
        raw = '0;
        for (int e = 0; e < 2; e++) begin
          low      = !ext_pin_n[e];
          edge_now = ext_edge_sel[e] && m_pin[e] && low;
          keep     = m_flag[e] && !(ok && win == 2 * e);
          nf[e]    = ext_edge_sel[e] && (keep || edge_now);
          raw[2*e] = ext_edge_sel[e] ? nf[e] : low;
        end
        raw[1] = tmr_flag[0]; raw[3] = tmr_flag[1]; raw[4] = ser_flag; raw[5] = tmr_flag[2];
        m_pin = ext_pin_n; m_flag = nf; m_samp = raw;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 model vec_req", {31'b0, vec_req}, {31'b0, m_req});
      if (m_req) check("R4 model vec_addr", {16'b0, vec_addr}, m_addr);
      check("R12 model in_svc", {30'b0, in_svc}, {30'b0, m_svc});
      check("R9 model ext_flag", {30'b0, ext_flag}, {30'b0, m_flag});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic mcyc(input bit with_reti);
    @(negedge clk) begin mc_stb = 1; reti_stb = with_reti; end
    @(negedge clk) begin mc_stb = 0; reti_stb = 0; end
    got_req = vec_req; got_addr = vec_addr; got_hi = vec_hi;
    repeat (2) @(negedge clk);
  endtask

  task automatic reti_pulse();
    @(negedge clk) reti_stb = 1;
    @(negedge clk) reti_stb = 0;
  endtask

  initial begin
    rst_n = 0; mc_stb = 0; ext_pin_n = 2'b11; ext_edge_sel = 2'b00; tmr_flag = 0;
    ser_flag = 0; src_en = 0; src_hi = 0; glb_en = 0; insn_last = 1; insn_block = 0;
    reti_stb = 0;
    repeat (3) @(negedge clk);
    check("R1 reset vec_req", {31'b0, vec_req}, 0);
    check("R1 reset in_svc", {30'b0, in_svc}, 0);
    check("R1 reset ext_flag", {30'b0, ext_flag}, 0);
    rst_n = 1;
    glb_en = 1; src_en = 6'h3F;

    // R2: sample first, vector at next strobe
    tmr_flag[0] = 1;
    mcyc(0); check("R2 sample only", {31'b0, got_req}, 0);
    mcyc(0); check("R2 vector next strobe", {31'b0, got_req}, 1);
    check("R4 timer0 address", {16'b0, got_addr}, 32'h000B);
    check("R6 low level marked", {30'b0, in_svc}, 2'b01);

    // R6: high preempts low
    tmr_flag[0] = 0; tmr_flag[1] = 1; src_hi = 6'b001000;
    mcyc(0); mcyc(0);
    check("R6 preempt req", {31'b0, got_req}, 1);
    check("R4 timer1 address", {16'b0, got_addr}, 32'h001B);
    check("R4 vec_hi", {31'b0, got_hi}, 1);
    check("R6 both levels", {30'b0, in_svc}, 2'b11);

    // R6: nothing nests on high
    tmr_flag[1] = 0; tmr_flag[2] = 1; src_hi = 6'b100000;
    mcyc(0); check("R6 high blocked a", {31'b0, got_req}, 0);
    mcyc(0); check("R6 high blocked b", {31'b0, got_req}, 0);
    reti_pulse();
    check("R12 release high first", {30'b0, in_svc}, 2'b01);
    mcyc(0); check("R4 timer2 address", {16'b0, got_addr}, 32'h002B);
    reti_pulse();
    mcyc(0); check("R11 timer re-request", {31'b0, got_req}, 1);
    tmr_flag[2] = 0; insn_last = 0; mcyc(0); insn_last = 1;
    reti_pulse(); reti_pulse();
    check("R12 all released", {30'b0, in_svc}, 2'b00);

    // R3/R4 polling order sweep
    src_hi = 0; ext_pin_n = 2'b00; tmr_flag = 3'b111; ser_flag = 1;
    insn_last = 0; mcyc(0); insn_last = 1;
    for (int k = 0; k < 6; k++) begin
      src_en = 6'(6'h3F << k);
      mcyc(0);
      check("R3 order winner", {16'b0, got_addr}, 3 + 8 * k);
      reti_pulse();
    end
    src_en = 6'h3F; src_hi = 6'b010000;
    mcyc(0);
    check("R3 high beats low", {16'b0, got_addr}, 32'h0023);
    check("R3 high level", {31'b0, got_hi}, 1);
    reti_pulse(); src_hi = 0;

    // R5 gating
    glb_en = 0; mcyc(0); check("R5 global off", {31'b0, got_req}, 0);
    glb_en = 1; src_en = 0; mcyc(0); check("R5 source off", {31'b0, got_req}, 0);
    src_en = 6'h3F;

    // R7 instruction blocking
    insn_last = 0; mcyc(0); check("R7 not final", {31'b0, got_req}, 0);
    insn_last = 1; insn_block = 1; mcyc(0); check("R7 blocking insn", {31'b0, got_req}, 0);
    insn_block = 0; mcyc(0); check("R7 released", {16'b0, got_addr}, 32'h0003);
    reti_pulse();
    ext_pin_n = 2'b11; tmr_flag = 0; ser_flag = 0;
    insn_last = 0; mcyc(0); insn_last = 1;

    // R8 lost request
    tmr_flag[0] = 1; mcyc(0);
    insn_last = 0; mcyc(0);
    tmr_flag[0] = 0; mcyc(0);
    insn_last = 1; mcyc(0);
    check("R8 lost request", {31'b0, got_req}, 0);

    // R9 edge mode
    ext_edge_sel = 2'b10; mcyc(0);
    ext_pin_n[1] = 0; mcyc(0);
    check("R9 flag set", {30'b0, ext_flag}, 2'b10);
    mcyc(0);
    check("R9 edge vector", {16'b0, got_addr}, 32'h0013);
    check("R9 flag cleared", {30'b0, ext_flag}, 2'b00);
    reti_pulse();
    mcyc(0); mcyc(0);
    check("R9 held low no repeat", {31'b0, got_req}, 0);
    ext_pin_n[1] = 1;

    // R10 level mode
    ext_edge_sel = 2'b00; ext_pin_n[1] = 0;
    mcyc(0); mcyc(0);
    check("R10 level vector", {16'b0, got_addr}, 32'h0013);
    check("R10 no flag", {30'b0, ext_flag}, 2'b00);
    reti_pulse();
    mcyc(0); check("R10 level repeat", {31'b0, got_req}, 1);
    reti_pulse();
    ext_pin_n = 2'b11; insn_last = 0; mcyc(0); insn_last = 1;

    // R12 grant and release in one clock
    tmr_flag[0] = 1; mcyc(0); mcyc(0);
    check("R12 setup low", {30'b0, in_svc}, 2'b01);
    tmr_flag[0] = 0; tmr_flag[1] = 1; src_hi = 6'b001000;
    mcyc(0); mcyc(1);
    check("R12 swap vector", {16'b0, got_addr}, 32'h001B);
    check("R12 swap in_svc", {30'b0, in_svc}, 2'b10);
    tmr_flag[1] = 0; mcyc(0);
    tmr_flag[0] = 1; mcyc(0); mcyc(1);
    check("R12 low refused at release", {31'b0, got_req}, 0);
    check("R12 release to idle", {30'b0, in_svc}, 2'b00);
    tmr_flag[0] = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule